// File: doc/BRIEF.md
# Ultra DMA Burst Timing Engine

This block is the host-side timing engine for Ultra DMA bursts on a parallel ATA channel that serves four drives. It keeps a timing record for each drive. The record holds a base clock choice, a fast-mode bit, a strobe cycle count and a ready-to-pause count. When a burst starts, the engine copies the record of the target drive, and that copy sets all of its timing until the burst is over.

In a write burst the engine takes 16-bit words from a first-word-fall-through host FIFO. It toggles its data strobe and puts out one word on every strobe edge, rising or falling. The strobe holds its level for a programmed number of base clock ticks. In a read burst the device drives the strobe, and the engine captures one word on each device strobe edge. To end a read, the engine raises its ready line, waits the programmed number of base ticks, and then raises STOP. Every burst ends with a one-cycle STOP, then a one-cycle done pulse that comes with the final word count. Base clocks arrive as clock-enable ticks on a small vector of inputs.

Top module: `udma_burst_engine`

## Requirements
- R1: After reset, host_strobe is 0, host_dmardy_n is 1, and host_stop, done, busy, fifo_rd and rd_valid are all 0.
- R2: Timing for a burst is counted in ticks of base_tick[sel], where sel is the 2-bit base clock field of the drive named by start_drive. When that drive's fast bit is 1, base_tick[0] is used instead, whatever sel holds.
- R3: In a write burst with data available and dev_dmardy_n low, host_strobe holds each level for exactly ct base ticks, where ct is the drive's cycle count. A cycle count of 0 acts as 1.
- R4: Each host_strobe edge of a write burst comes with exactly one fifo_rd pulse. host_data then shows the popped FIFO word, and words go out in FIFO order.
- R5: While fifo_empty is 1 or dev_dmardy_n is 1 during a write burst, host_strobe holds its level and fifo_rd stays 0.
- R6: During a read burst host_dmardy_n is 0. Each edge of dev_strobe, rising or falling, captures dev_data into rd_data, and rd_valid is 1 in the following cycle.
- R7: When term is sampled in a read burst, host_dmardy_n goes to 1 on that edge. host_stop then rises after exactly rp base ticks, where rp is the drive's pause count. A pause count of 0 acts as 1.
- R8: host_stop is 1 for one cycle. done is 1 for the next cycle only, and word_cnt then equals the number of words moved in the burst.
- R9: A settings write to a drive during a burst to that drive does not change the running burst. The new values apply from the next burst.
- R10: When term is sampled during a write burst, host_stop is 1 after that edge and no further strobe edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 4 | Base clock enable ticks, one per base clock choice |
| cfg_we | input | 1 | Write one drive's timing settings |
| cfg_drive | input | 2 | Drive whose settings are written |
| cfg_sel | input | 2 | Base clock choice |
| cfg_fast | input | 1 | Fast-mode bit |
| cfg_ct | input | 4 | Strobe cycle count in base ticks |
| cfg_rp | input | 4 | Ready-to-pause count in base ticks |
| start | input | 1 | Begin a burst (honoured when idle) |
| start_read | input | 1 | 1 for a read burst, 0 for a write burst |
| start_drive | input | 2 | Target drive of the burst |
| term | input | 1 | Host request to end the burst |
| fifo_data | input | 16 | Head word of the host FIFO |
| fifo_empty | input | 1 | Host FIFO has no word |
| fifo_rd | output | 1 | Pop the host FIFO head |
| dev_dmardy_n | input | 1 | Device not ready (write pause), active low ready |
| dev_strobe | input | 1 | Device data strobe for reads |
| dev_data | input | 16 | Device read data |
| host_strobe | output | 1 | Host data strobe for writes |
| host_data | output | 16 | Host write data |
| host_dmardy_n | output | 1 | Host ready for reads, active low |
| host_stop | output | 1 | STOP to the device |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | rd_data holds a new word |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| word_cnt | output | 16 | Words moved in the last or current burst |

## Verification
The hardest case to reach is a settings write to the very drive a burst is using, arriving in the middle of that burst. The bench covers it by forking a settings write against a running strobe measurement, so the write lands between strobe edges. It then checks that the burst keeps its old spacing and that the next burst takes the new one. Paused write strobes are produced by draining the bench FIFO and then holding the device ready line high with data pending. On resume, the bench skips the interval check for the first edge, because that edge follows a saturated count.

// File: rtl/udma_pkg.sv
package udma_pkg;
  localparam int SEL_W = 2;
  localparam int CT_W  = 4;

  typedef struct packed {
    logic             fast;
    logic [SEL_W-1:0] sel;
    logic [CT_W-1:0]  ct;
    logic [CT_W-1:0]  rp;
  } drv_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RPAUSE,
    ST_FIN
  } eng_state_t;

  function automatic logic [CT_W-1:0] eff_last(input logic [CT_W-1:0] v);
    // last counter value of a window of v ticks, zero acting as one
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/udma_cfg_bank.sv
module udma_cfg_bank
  import udma_pkg::*;
#(
  parameter int NDRV = 4,
  localparam int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [DRV_W-1:0] wsel,
  input  drv_cfg_t         wdata,
  input  logic [DRV_W-1:0] rsel,
  output drv_cfg_t         rdata
);
  drv_cfg_t mem_q [NDRV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDRV; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[wsel] <= wdata;
    end
  end

  assign rdata = mem_q[rsel];
endmodule

// File: rtl/udma_tick_sel.sv
module udma_tick_sel
  import udma_pkg::*;
#(
  parameter int FAST_IDX = 0,
  localparam int NCLK = 1 << SEL_W
) (
  input  logic [NCLK-1:0] base_tick,
  input  drv_cfg_t        cfg,
  output logic            tick
);
  assign tick = cfg.fast ? base_tick[FAST_IDX] : base_tick[cfg.sel];
endmodule

// File: rtl/udma_rd_capture.sv
module udma_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dev_strobe,
  input  logic [DW-1:0] dev_data,
  output logic          hit,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic strb_q;

  assign hit = en && (dev_strobe != strb_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      strb_q   <= dev_strobe;
      rd_valid <= hit;
      if (hit) rd_data <= dev_data;
    end
  end
endmodule

// File: rtl/udma_burst_engine.sv
module udma_burst_engine
  import udma_pkg::*;
#(
  parameter int NDRV     = 4,
  parameter int DW       = 16,
  parameter int CNT_W    = 16,
  parameter int FAST_IDX = 0,
  localparam int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int NCLK  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCLK-1:0]  base_tick,
  input  logic             cfg_we,
  input  logic [DRV_W-1:0] cfg_drive,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_fast,
  input  logic [CT_W-1:0]  cfg_ct,
  input  logic [CT_W-1:0]  cfg_rp,
  input  logic             start,
  input  logic             start_read,
  input  logic [DRV_W-1:0] start_drive,
  input  logic             term,
  input  logic [DW-1:0]    fifo_data,
  input  logic             fifo_empty,
  output logic             fifo_rd,
  input  logic             dev_dmardy_n,
  input  logic             dev_strobe,
  input  logic [DW-1:0]    dev_data,
  output logic             host_strobe,
  output logic [DW-1:0]    host_data,
  output logic             host_dmardy_n,
  output logic             host_stop,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] word_cnt
);
  eng_state_t      st_q;
  drv_cfg_t        act_q, bank_rd, wcfg;
  logic [CT_W-1:0] cnt_q;
  logic            cur_tick, hit, rd_phase, ct_last, rp_last, wr_fire;

  assign wcfg = '{fast: cfg_fast, sel: cfg_sel, ct: cfg_ct, rp: cfg_rp};

  udma_cfg_bank #(.NDRV(NDRV)) i_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .wsel(cfg_drive), .wdata(wcfg),
    .rsel(start_drive), .rdata(bank_rd)
  );

  udma_tick_sel #(.FAST_IDX(FAST_IDX)) i_tick (
    .base_tick(base_tick), .cfg(act_q), .tick(cur_tick)
  );

  assign rd_phase = (st_q == ST_RD) || (st_q == ST_RPAUSE);

  udma_rd_capture #(.DW(DW)) i_cap (
    .clk(clk), .rst(rst), .en(rd_phase), .dev_strobe(dev_strobe),
    .dev_data(dev_data), .hit(hit), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign ct_last = (cnt_q == eff_last(act_q.ct));
  assign rp_last = (cnt_q == eff_last(act_q.rp));
  assign wr_fire = (st_q == ST_WR) && !term && cur_tick && ct_last &&
                   !fifo_empty && !dev_dmardy_n;
  assign fifo_rd = wr_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      act_q         <= '0;
      cnt_q         <= '0;
      host_strobe   <= 1'b0;
      host_data     <= '0;
      host_dmardy_n <= 1'b1;
      host_stop     <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      word_cnt      <= '0;
    end else begin
      done <= 1'b0;
      if (wr_fire || hit) word_cnt <= word_cnt + 1'b1;
      case (st_q)
        ST_IDLE: if (start) begin
          act_q         <= bank_rd;
          cnt_q         <= '0;
          word_cnt      <= '0;
          busy          <= 1'b1;
          host_dmardy_n <= !start_read;
          st_q          <= start_read ? ST_RD : ST_WR;
        end
        ST_WR: begin
          if (term) begin
            host_stop <= 1'b1;
            st_q      <= ST_FIN;
          end else if (wr_fire) begin
            host_strobe <= !host_strobe;
            host_data   <= fifo_data;
            cnt_q       <= '0;
          end else if (cur_tick && !ct_last) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD: if (term) begin
          host_dmardy_n <= 1'b1;
          cnt_q         <= '0;
          st_q          <= ST_RPAUSE;
        end
        ST_RPAUSE: if (cur_tick) begin
          if (rp_last) begin
            host_stop <= 1'b1;
            st_q      <= ST_FIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIN: begin
          host_stop <= 1'b0;
          done      <= 1'b1;
          busy      <= 1'b0;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module udma_burst_chk (
  input logic clk,
  input logic rst,
  input logic fifo_rd,
  input logic fifo_empty,
  input logic host_strobe,
  input logic host_stop,
  input logic host_dmardy_n,
  input logic done,
  input logic rd_phase,
  input logic cur_tick
);
  p_pop_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> cur_tick);

  p_pop_toggles_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> (host_strobe != $past(host_strobe)));

  p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_rd);

  p_stop_ready_high_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(host_stop) && $past(rd_phase) |-> host_dmardy_n);

  p_done_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
    host_stop |=> (done && !host_stop));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind udma_burst_engine udma_burst_chk i_chk (
  .clk(clk), .rst(rst), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
  .host_strobe(host_strobe), .host_stop(host_stop),
  .host_dmardy_n(host_dmardy_n), .done(done), .rd_phase(rd_phase),
  .cur_tick(cur_tick)
);

// File: tb/test_udma_burst_engine.sv
`timescale 1ns/1ps
module test_udma_burst_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  base_tick;
  logic        cfg_we = 0, cfg_fast = 0;
  logic [1:0]  cfg_drive = 0, cfg_sel = 0, start_drive = 0;
  logic [3:0]  cfg_ct = 0, cfg_rp = 0;
  logic        start = 0, start_read = 0, term = 0;
  logic [15:0] fifo_data;
  logic        fifo_empty, fifo_rd;
  logic        dev_dmardy_n = 0, dev_strobe = 0;
  logic [15:0] dev_data = 0;
  logic        host_strobe, host_dmardy_n, host_stop, rd_valid, busy, done;
  logic [15:0] host_data, rd_data, word_cnt;

  int checks = 0, fails = 0, cyc = 0, rd_idx = 0, fifo_n = 0, widx = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_rd) rd_idx <= rd_idx + 1;
  end

  always_comb begin
    for (int k = 0; k < 4; k++) base_tick[k] = ((cyc % (k + 1)) == 0);
  end

  function automatic logic [15:0] wpat(input int i);
    return 16'(i * 16'h0123 + 16'h5A00);
  endfunction

  assign fifo_data  = wpat(rd_idx);
  assign fifo_empty = (rd_idx >= fifo_n);

  udma_burst_engine i_udma_burst_engine (
    .clk(clk), .rst(rst), .base_tick(base_tick), .cfg_we(cfg_we),
    .cfg_drive(cfg_drive), .cfg_sel(cfg_sel), .cfg_fast(cfg_fast),
    .cfg_ct(cfg_ct), .cfg_rp(cfg_rp), .start(start), .start_read(start_read),
    .start_drive(start_drive), .term(term), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .dev_dmardy_n(dev_dmardy_n),
    .dev_strobe(dev_strobe), .dev_data(dev_data), .host_strobe(host_strobe),
    .host_data(host_data), .host_dmardy_n(host_dmardy_n),
    .host_stop(host_stop), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .word_cnt(word_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int d, input int sel, input bit fast, input int ct, input int rp);
    @(negedge clk);
    cfg_we = 1; cfg_drive = 2'(d); cfg_sel = 2'(sel); cfg_fast = fast;
    cfg_ct = 4'(ct); cfg_rp = 4'(rp);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic begin_burst(input int d, input bit rd);
    @(negedge clk);
    start = 1; start_read = rd; start_drive = 2'(d);
    @(negedge clk);
    start = 0;
  endtask

  // count strobe edges; each interval measured in base_tick[idx] ticks
  task automatic wr_toggles(input int n, input int ct, input int idx,
                            input bit chk_first, input string tag);
    int seen = 0, ticks = 0, guard = 0;
    logic prev = host_strobe;
    while (seen < n && guard < 2000) begin
      if (host_strobe != prev) begin
        chk(host_data == wpat(widx), {tag, " R4 data"}, host_data, wpat(widx));
        if (seen > 0 || chk_first)
          chk(ticks == ct, {tag, " R3 strobe width"}, ticks, ct);
        widx++; seen++; ticks = 0; prev = host_strobe;
      end
      if (base_tick[idx]) ticks++;
      guard++;
      @(negedge clk);
    end
    chk(seen == n, {tag, " R4 edge count"}, seen, n);
  endtask

  task automatic end_write(input int exp_words, input string tag);
    logic s;
    term = 1;
    @(negedge clk);
    term = 0;
    s = host_strobe;
    chk(host_stop == 1, {tag, " R10 stop after term"}, host_stop, 1);
    @(negedge clk);
    chk(done == 1 && host_stop == 0, {tag, " R8 done pulse"}, {done, host_stop}, 2'b10);
    chk(word_cnt == 16'(exp_words), {tag, " R8 word count"}, word_cnt, exp_words);
    chk(host_strobe == s, {tag, " R10 no edge after term"}, host_strobe, s);
    @(negedge clk);
    chk(done == 0, {tag, " R8 done single"}, done, 0);
  endtask

  task automatic test_reset();
    chk(host_strobe == 0 && host_dmardy_n == 1 && host_stop == 0 && done == 0 &&
        busy == 0 && fifo_rd == 0 && rd_valid == 0, "R1 reset state",
        {host_strobe, host_dmardy_n, host_stop, done, busy, fifo_rd, rd_valid}, 7'b0100000);
  endtask

  task automatic test_write_pause();
    int gotrd = 0;
    logic s;
    fifo_n = rd_idx + 4;
    begin_burst(0, 0);
    wr_toggles(4, 3, 1, 1, "d0 write");
    s = host_strobe;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fifo_rd) gotrd++;
    end
    chk(host_strobe == s && gotrd == 0, "R5 empty pause", {host_strobe, 4'(gotrd)}, {s, 4'd0});
    dev_dmardy_n = 1;
    fifo_n = fifo_n + 2;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (fifo_rd) gotrd++;
    end
    chk(host_strobe == s && gotrd == 0, "R5 not-ready pause", {host_strobe, 4'(gotrd)}, {s, 4'd0});
    dev_dmardy_n = 0;
    wr_toggles(2, 3, 1, 0, "d0 resume");
    end_write(6, "d0");
  endtask

  task automatic test_write_simple(input int d, input int ct, input int idx,
                                   input int n, input string tag);
    fifo_n = rd_idx + n + 2;
    begin_burst(d, 0);
    wr_toggles(n, ct, idx, 1, tag);
    end_write(n, tag);
  endtask

  task automatic test_cfg_mid_burst();
    fifo_n = rd_idx + 10;
    begin_burst(3, 0);
    fork
      wr_toggles(4, 4, 0, 1, "R9 old ct kept");
      begin
        repeat (6) @(negedge clk);
        cfg_we = 1; cfg_drive = 2'd3; cfg_sel = 2'd0; cfg_fast = 0;
        cfg_ct = 4'd2; cfg_rp = 4'd0;
        @(negedge clk);
        cfg_we = 0;
      end
    join
    end_write(4, "R9 burst a");
    fifo_n = rd_idx + 5;
    begin_burst(3, 0);
    wr_toggles(3, 2, 0, 1, "R9 new ct used");
    end_write(3, "R9 burst b");
  endtask

  task automatic test_read(input int d, input int rp, input int idx,
                           input int n, input string tag);
    int ticks = 0, guard = 0;
    begin_burst(d, 1);
    chk(host_dmardy_n == 0 && busy == 1, {tag, " R6 ready low"}, host_dmardy_n, 0);
    for (int i = 0; i < n; i++) begin
      dev_data = 16'(16'hC300 + i * 7);
      dev_strobe = ~dev_strobe;
      @(negedge clk);
      chk(rd_valid == 1 && rd_data == 16'(16'hC300 + i * 7), {tag, " R6 capture"},
          rd_data, 16'hC300 + i * 7);
      @(negedge clk);
      chk(rd_valid == 0, {tag, " R6 valid single"}, rd_valid, 0);
    end
    term = 1;
    @(negedge clk);
    term = 0;
    chk(host_dmardy_n == 1 && host_stop == 0, {tag, " R7 ready high"},
        {host_dmardy_n, host_stop}, 2'b10);
    while (!host_stop && guard < 200) begin
      if (base_tick[idx]) ticks++;
      guard++;
      @(negedge clk);
    end
    chk(ticks == rp, {tag, " R7 pause ticks"}, ticks, rp);
    @(negedge clk);
    chk(done == 1 && word_cnt == 16'(n), {tag, " R8 read count"}, word_cnt, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    set_cfg(0, 1, 0, 3, 2);
    set_cfg(1, 2, 0, 0, 5);
    set_cfg(2, 3, 1, 2, 3);
    set_cfg(3, 0, 0, 4, 0);
    test_write_pause();
    test_write_simple(1, 1, 2, 4, "R3 zero ct d1");
    test_write_simple(2, 2, 0, 4, "R2 fast d2");
    test_cfg_mid_burst();
    test_read(0, 2, 1, 5, "d0 read");
    test_read(3, 1, 0, 3, "R7 zero rp d3");
    test_read(1, 5, 2, 2, "R2 d1 read");
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule